// File: doc/BRIEF.md
# Prescaled Overflow Timer

An 8-bit up-counting timer advanced by the processor's instruction-cycle strobe. A programmable prescaler can sit between the strobe and the timer. With the prescaler bypassed, the timer advances on every strobe. Otherwise it advances once per 2^(code+1) strobes, where code is a 3-bit rate field.

When the count wraps from FFh to 00h, the timer sets a sticky overflow flag. The flag drives a level interrupt output through an enable bit. Software clears the flag by writing a 0 to it.

Software reaches the block through a small register port with three addresses:
- a prescaler control byte;
- the live count;
- an interrupt control byte holding the enable and the flag.

Any write to the control byte or to the count restarts the prescaler's divide chain. This lets firmware start a measured interval on a known phase.

Top module: `ovf_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0Fh, the count (address 1) reads 00h, the interrupt register (address 2) reads 00h, and irq_o is low.
- R2: When the bypass bit (bit 3 of address 0) is 1, the count increments by one in the cycle after each cycle in which tick_i is high.
- R3: When the bypass bit is 0, the rate field (bits 2:0 of address 0) selects one increment per 2, 4, 8, 16, 32, 64, 128 or 256 ticks for codes 0 to 7. Counting starts from a cleared divide chain.
- R4: A write to address 0 or address 1 clears the divide chain, so a partial prescaler period is discarded.
- R5: A write to address 1 loads the written byte into the count, and it wins over an increment in the same cycle.
- R6: An increment from FFh wraps the count to 00h and sets the overflow flag, which is bit 2 of address 2.
- R7: The overflow flag holds once set. Writing 0 to bit 2 of address 2 clears it. Writing 1 leaves it unchanged.
- R8: Bit 5 of address 2 is the interrupt enable, and irq_o is high exactly when both the flag and the enable are 1.
- R9: If an overflow and a software clear of the flag fall in the same cycle, the flag ends up set.
- R10: Reads have no side effects. Unused bits read 0, and address 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Instruction-cycle strobe, one cycle wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that each register access lasts exactly one cycle. They also assume that addr_i and wdata_i are stable around the sampling edge. Beyond that, they place no limit on how writes and ticks combine.

The bench changes every input on the falling clock edge and releases the write strobe after one cycle. It deliberately drives some writes in the same cycle as a tick. This exercises the load-wins and set-wins orderings without breaking those assumptions.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_IRQ  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_BYPASS_BIT = 3;
  localparam int unsigned IRQ_FLAG_BIT    = 2;
  localparam int unsigned IRQ_EN_BIT      = 5;
endpackage

// File: rtl/ovf_prescaler.sv
module ovf_prescaler #(
  parameter int unsigned RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clear_i,
  input  logic              bypass_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              inc_o
);
  localparam int unsigned PRE_W = 1 << RATE_W;

  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  mask;
  logic [RATE_W-1:0] shamt;
  logic              hit;

  // mask of (rate+1) low ones: period 2^(rate+1)
  assign shamt = RATE_W'(PRE_W - 1) - rate_i;
  assign mask  = {PRE_W{1'b1}} >> shamt;
  assign hit   = (pre_q & mask) == mask;
  assign inc_o = tick_i & (bypass_i | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (tick_i)  pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ovf_count.sv
module ovf_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign count_o = cnt_q;
  assign ovf_o   = inc_i & ~load_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ovf_irq_ctl.sv
module ovf_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic wr_i,
  input  logic wflag_i,
  input  logic wen_i,
  output logic flag_o,
  output logic en_o,
  output logic irq_o
);
  logic flag_q, en_q;

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = flag_q & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      // software may only clear; overflow set wins
      flag_q <= ovf_i | (flag_q & ~(wr_i & ~wflag_i));
      if (wr_i) en_q <= wen_i;
    end
  end
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned RATE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  logic              bypass_q;
  logic [RATE_W-1:0] rate_q;
  logic              wr_ctrl, wr_cnt, wr_irq;
  logic              inc, ovf, flag, irq_en;
  logic [CNT_W-1:0]  count_q;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_cnt  = we_i && (addr_i == ADDR_CNT);
  assign wr_irq  = we_i && (addr_i == ADDR_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_q <= 1'b1;
      rate_q   <= '1;
    end else if (wr_ctrl) begin
      bypass_q <= wdata_i[CTRL_BYPASS_BIT];
      rate_q   <= wdata_i[RATE_W-1:0];
    end
  end

  ovf_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clear_i (wr_ctrl | wr_cnt),
    .bypass_i(bypass_q),
    .rate_i  (rate_q),
    .inc_o   (inc)
  );

  ovf_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .load_i    (wr_cnt),
    .load_val_i(wdata_i),
    .count_o   (count_q),
    .ovf_o     (ovf)
  );

  ovf_irq_ctl u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ovf_i  (ovf),
    .wr_i   (wr_irq),
    .wflag_i(wdata_i[IRQ_FLAG_BIT]),
    .wen_i  (wdata_i[IRQ_EN_BIT]),
    .flag_o (flag),
    .en_o   (irq_en),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_BYPASS_BIT] = bypass_q;
        rdata_o[RATE_W-1:0]      = rate_q;
      end
      ADDR_CNT:  rdata_o = count_q;
      ADDR_IRQ: begin
        rdata_o[IRQ_FLAG_BIT] = flag;
        rdata_o[IRQ_EN_BIT]   = irq_en;
      end
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk
  import ovf_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] count_i,
  input logic             tick_i,
  input logic             bypass_i,
  input logic             inc_i,
  input logic             flag_i,
  input logic             en_i,
  input logic             irq_i
);
  logic cnt_wr, clr_wr;
  assign cnt_wr = we_i && (addr_i == ADDR_CNT);
  assign clr_wr = we_i && (addr_i == ADDR_IRQ) && !wdata_i[IRQ_FLAG_BIT];

  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> count_i == $past(wdata_i));

  a_r2_bypass_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && bypass_i && !cnt_wr |=> count_i == CNT_W'($past(count_i) + 1'b1));

  a_r6_wrap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && (&count_i) && !cnt_wr |=> flag_i && count_i == '0);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && !clr_wr |=> flag_i);

  a_r8_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> flag_i && en_i);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !cnt_wr |=> $stable(count_i));
endmodule

bind ovf_timer ovf_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .count_i (count_q),
  .tick_i  (tick_i),
  .bypass_i(bypass_q),
  .inc_i   (inc),
  .flag_i  (flag),
  .en_i    (irq_en),
  .irq_i   (irq_o)
);

// File: tb/ovf_timer_test.sv
module ovf_timer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk_i = ~clk_i;

  ovf_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // {bypass, rate, ticks, expected count}
  typedef struct packed {
    logic       byp;
    logic [2:0] rate;
    logic [15:0] ticks;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 16'd5,   8'd5},
    '{1'b0, 3'd0, 16'd7,   8'd3},
    '{1'b0, 3'd1, 16'd9,   8'd2},
    '{1'b0, 3'd2, 16'd16,  8'd2},
    '{1'b0, 3'd3, 16'd33,  8'd2},
    '{1'b0, 3'd4, 16'd64,  8'd2},
    '{1'b0, 3'd5, 16'd200, 8'd3},
    '{1'b0, 3'd6, 16'd255, 8'd1},
    '{1'b0, 3'd7, 16'd512, 8'd2},
    '{1'b0, 3'd7, 16'd255, 8'd0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d; tick_i = tk;
    @(negedge clk_i);
    we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
    end
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  initial begin
    logic [7:0] r;
    #20 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, r); check("R1 ctrl", r, 8'h0F);
    rd(2'd1, r); check("R1 count", r, 8'h00);
    rd(2'd2, r); check("R1 irq reg", r, 8'h00);
    check("R1 irq_o", {7'd0, irq_o}, 8'h00);
    rd(2'd3, r); check("R10 unused addr", r, 8'h00);

    // R2/R3 table walk
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, {4'd0, VECS[v].byp, VECS[v].rate}, 1'b0);
      wr(2'd1, 8'h00, 1'b0);
      ticks(int'(VECS[v].ticks));
      rd(2'd1, r);
      check(VECS[v].byp ? "R2 bypass rate" : "R3 prescale rate", r, VECS[v].exp);
    end

    // R10 control readback and non-disturbing reads
    wr(2'd0, 8'hF5, 1'b0);
    rd(2'd0, r); check("R10 ctrl readback", r, 8'h05);
    wr(2'd1, 8'h5A, 1'b0);
    rd(2'd1, r); rd(2'd1, r); rd(2'd1, r);
    check("R5 R10 load and stable read", r, 8'h5A);

    // R4 write clears partial divide period (rate 0 = /2)
    wr(2'd0, 8'h00, 1'b0);
    wr(2'd1, 8'h10, 1'b0);
    ticks(1);
    wr(2'd0, 8'h00, 1'b0);
    ticks(1);
    rd(2'd1, r); check("R4 ctrl write restarts chain", r, 8'h10);
    ticks(1);
    rd(2'd1, r); check("R4 count after full period", r, 8'h11);
    ticks(1);
    wr(2'd1, 8'h20, 1'b0);
    ticks(1);
    rd(2'd1, r); check("R4 count write restarts chain", r, 8'h20);

    // R5 load wins over same-cycle increment
    wr(2'd0, 8'h08, 1'b0);
    wr(2'd1, 8'h33, 1'b1);
    rd(2'd1, r); check("R5 load beats tick", r, 8'h33);

    // R6 R8 wrap, flag, interrupt
    wr(2'd2, 8'h20, 1'b0);
    wr(2'd1, 8'hFE, 1'b0);
    ticks(1);
    rd(2'd2, r); check("R6 no flag before wrap", r, 8'h20);
    ticks(1);
    rd(2'd1, r); check("R6 wrap to zero", r, 8'h00);
    rd(2'd2, r); check("R6 flag set", r, 8'h24);
    check("R8 irq_o high", {7'd0, irq_o}, 8'h01);

    // R7 sticky, write 1 keeps, write 0 clears
    ticks(3);
    wr(2'd2, 8'h24, 1'b0);
    rd(2'd2, r); check("R7 flag holds", r, 8'h24);
    wr(2'd2, 8'h20, 1'b0);
    rd(2'd2, r); check("R7 flag cleared", r, 8'h20);
    check("R8 irq_o low after clear", {7'd0, irq_o}, 8'h00);

    // R8 masking
    wr(2'd2, 8'h00, 1'b0);
    wr(2'd1, 8'hFF, 1'b0);
    ticks(1);
    rd(2'd2, r); check("R8 flag set while masked", r, 8'h04);
    check("R8 irq_o masked", {7'd0, irq_o}, 8'h00);
    wr(2'd2, 8'h24, 1'b0);
    check("R8 irq_o on enable", {7'd0, irq_o}, 8'h01);

    // R9 set wins over clear: flag set, count FF, tick with clear write
    wr(2'd1, 8'hFF, 1'b0);
    wr(2'd2, 8'h20, 1'b1);
    rd(2'd2, r); check("R9 set beats clear", r, 8'h24);
    rd(2'd1, r); check("R9 count wrapped", r, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule